// File: doc/BRIEF.md
# Dual 8-bit Expansion Port Register Block

This block gives a host two general-purpose 8-bit ports. It uses the same narrow byte bus, 3-bit register select and active-low strobes that serve a larger memory device. Each port has an output latch and a per-bit direction register. A pin drives its latch bit when its direction bit is 1. When its direction bit is 0 the pin floats and acts as an input. Each pin is brought out as three separate signals: an output value, an output enable and a sampled input. A pad ring or a testbench resolves them into a real tri-state pin.

Reading a port register returns a per-bit mix. Bits in output mode show the latch value. Bits in input mode show the pin level after a two-stage synchroniser. Direction registers read back unchanged. When the select is high, the chip is deselected: every access is blocked, but the register contents and the pin drive stay as they were.

The strobes are sampled on the block clock. A write takes effect on the clock edge that sees the write strobe go from low to high. Read data is combinational and present for as long as the read strobe is low.

Top module: `xport_top`

## Requirements
- R1: After reset both output latches are 8'hFF, both direction registers are 8'h00 (every pin an input, every output enable low), and the read bus is not driven.
- R2: Select code 3'b100 addresses the port-0 latch, 3'b101 direction 0, 3'b110 the port-1 latch and 3'b111 direction 1. A write captures `wr_data` on the clock edge where `we_n` is sampled high after having been sampled low on the previous edge, with `cs_n` low. The new value appears the cycle after that edge.
- R3: For each port, `pN_oe` equals its direction register and `pN_out` equals its output latch.
- R4: Reading code 3'b101 or 3'b111 returns the direction register unchanged.
- R5: Reading code 3'b100 or 3'b110 returns, for each bit, the latch bit when the direction bit is 1 and the synchronised pin level when it is 0.
- R6: Pin levels pass through two flops. A change on `pN_in` first shows on a port read after the second rising clock edge.
- R7: While `cs_n` is high, writes have no effect, `rd_oe` stays low, and latches, directions and pin drive are unchanged.
- R8: With select bit 2 at 0 (memory space), writes leave all port registers unchanged and `rd_oe` stays low.
- R9: `rd_oe` is high only while `oe_n` and `cs_n` are low with select bit 2 at 1. Holding `we_n` low changes nothing until it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe, commits on its rise |
| oe_n | input | 1 | Active-low read strobe |
| sel | input | 3 | Register select |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Host read data, zero when not driven |
| rd_oe | output | 1 | Read bus drive enable |
| p0_out | output | 8 | Port 0 pin output values |
| p0_oe | output | 8 | Port 0 pin output enables |
| p0_in | input | 8 | Port 0 pin levels |
| p1_out | output | 8 | Port 1 pin output values |
| p1_oe | output | 8 | Port 1 pin output enables |
| p1_in | input | 8 | Port 1 pin levels |

## Verification
A register write is due one cycle after the edge that sees the write strobe rise. The bench drives the strobe low and then high on falling edges, and samples on the falling edge that follows the committing rising edge. Read data is combinational, so it is sampled a short delay after select and strobe settle. A pin change is due only after two rising edges, so the bench samples once after the first edge to confirm the old level and once after the second to confirm the new one.

// File: rtl/xport_pkg.sv
package xport_pkg;
    localparam int XP_W = 8;
    localparam int XP_SEL_W = 3;
    localparam logic [XP_W-1:0] XP_LATCH_RST = '1;
    localparam logic [XP_W-1:0] XP_DIR_RST = '0;

    typedef struct packed {
        logic [XP_W-1:0] latch;
        logic [XP_W-1:0] dir;
    } xp_bank_t;

    typedef struct packed {
        logic we_n;
    } xp_ctl_t;
endpackage

// File: rtl/xport_sync.sv
module xport_sync #(
    parameter int W = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign dout = stage_q[STAGES-1];

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_chk
            assert_stage_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> stage_q[g] == $past(stage_q[g-1]));
        end
    endgenerate
endmodule

// File: rtl/xport_bank.sv
module xport_bank
    import xport_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_latch,
    input  logic            wr_dir,
    input  logic [XP_W-1:0] wdata,
    input  logic [XP_W-1:0] pin_sync,
    output logic [XP_W-1:0] pin_out,
    output logic [XP_W-1:0] pin_oe,
    output logic [XP_W-1:0] rd_port,
    output logic [XP_W-1:0] rd_dir
);
    xp_bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_latch) bank_d.latch = wdata;
        if (wr_dir) bank_d.dir = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.latch <= XP_LATCH_RST;
            bank_q.dir   <= XP_DIR_RST;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign pin_out = bank_q.latch;
    assign pin_oe  = bank_q.dir;
    assign rd_dir  = bank_q.dir;
    assign rd_port = (bank_q.latch & bank_q.dir) | (pin_sync & ~bank_q.dir);

    assert_latch_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_latch |=> pin_out == $past(wdata));
    assert_latch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_latch |=> $stable(pin_out));
    assert_oe_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> pin_oe == $past(wdata));
    assert_oe_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(pin_oe));
endmodule

// File: rtl/xport_top.sv
module xport_top
    import xport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic [XP_SEL_W-1:0] sel,
    input  logic [XP_W-1:0]     wr_data,
    output logic [XP_W-1:0]     rd_data,
    output logic                rd_oe,
    output logic [XP_W-1:0]     p0_out,
    output logic [XP_W-1:0]     p0_oe,
    input  logic [XP_W-1:0]     p0_in,
    output logic [XP_W-1:0]     p1_out,
    output logic [XP_W-1:0]     p1_oe,
    input  logic [XP_W-1:0]     p1_in
);
    localparam int NPORT = 2;

    xp_ctl_t ctl_d, ctl_q;
    logic commit;
    logic [XP_W-1:0] pin_raw  [NPORT];
    logic [XP_W-1:0] pin_sync [NPORT];
    logic [XP_W-1:0] pin_out  [NPORT];
    logic [XP_W-1:0] pin_oe   [NPORT];
    logic [XP_W-1:0] rd_port  [NPORT];
    logic [XP_W-1:0] rd_dir   [NPORT];

    always_comb begin
        ctl_d = ctl_q;
        ctl_d.we_n = we_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q.we_n <= 1'b1;
        else        ctl_q <= ctl_d;
    end

    // Write commits on the sampled low-to-high step of the write strobe
    assign commit = !ctl_q.we_n && we_n && !cs_n && sel[2];

    assign pin_raw[0] = p0_in;
    assign pin_raw[1] = p1_in;

    genvar p;
    generate
        for (p = 0; p < NPORT; p++) begin : g_port
            logic hit;
            assign hit = commit && (sel[1] == p[0]);

            xport_sync #(.W(XP_W), .STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (pin_raw[p]),
                .dout (pin_sync[p])
            );

            xport_bank u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_latch(hit && !sel[0]),
                .wr_dir  (hit && sel[0]),
                .wdata   (wr_data),
                .pin_sync(pin_sync[p]),
                .pin_out (pin_out[p]),
                .pin_oe  (pin_oe[p]),
                .rd_port (rd_port[p]),
                .rd_dir  (rd_dir[p])
            );
        end
    endgenerate

    assign p0_out = pin_out[0];
    assign p0_oe  = pin_oe[0];
    assign p1_out = pin_out[1];
    assign p1_oe  = pin_oe[1];

    always_comb begin
        rd_oe   = !cs_n && !oe_n && sel[2];
        rd_data = '0;
        if (rd_oe) rd_data = sel[0] ? rd_dir[sel[1]] : rd_port[sel[1]];
    end

    assert_hold_deselected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(p0_out) && $stable(p0_oe) && $stable(p1_out) && $stable(p1_oe)));
    assert_memory_space_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sel[2] |=> ($stable(p0_out) && $stable(p0_oe) && $stable(p1_out) && $stable(p1_oe)));
    assert_strobe_low_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> ($stable(p0_out) && $stable(p0_oe) && $stable(p1_out) && $stable(p1_oe)));
    always_comb begin
        if (rst_n && cs_n) assert_quiet_bus_R7: assert (!rd_oe && rd_data == '0);
    end
endmodule

// File: tb/xport_top_bench.sv
module xport_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NROWS = 8;
    // wsel, wdata, rsel, expected read
    localparam logic [21:0] TABLE [NROWS] = '{
        {3'b101, 8'hF0, 3'b101, 8'hF0},
        {3'b111, 8'h0F, 3'b111, 8'h0F},
        {3'b100, 8'h12, 3'b100, 8'h15},
        {3'b110, 8'h34, 3'b110, 8'hC4},
        {3'b101, 8'hFF, 3'b100, 8'h12},
        {3'b111, 8'h00, 3'b110, 8'hC9},
        {3'b000, 8'h77, 3'b101, 8'hFF},
        {3'b100, 8'hAB, 3'b100, 8'hAB}
    };

    logic clk = 0, rst_n = 0, cs_n = 1, we_n = 1, oe_n = 1;
    logic [2:0] sel = 3'b100;
    logic [7:0] wr_data = 0, p0_in = 0, p1_in = 0;
    logic [7:0] rd_data, p0_out, p0_oe, p1_out, p1_oe;
    logic rd_oe;
    int total = 0, bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xport_top u_xport_top (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .sel(sel), .wr_data(wr_data), .rd_data(rd_data), .rd_oe(rd_oe),
        .p0_out(p0_out), .p0_oe(p0_oe), .p0_in(p0_in),
        .p1_out(p1_out), .p1_oe(p1_oe), .p1_in(p1_in)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk); sel = s; wr_data = d; we_n = 0;
        @(negedge clk); we_n = 1;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [2:0] s, output logic [7:0] d, output logic oe);
        @(negedge clk); sel = s; oe_n = 0;
        #1; d = rd_data; oe = rd_oe;
        @(negedge clk); oe_n = 1;
    endtask

    initial begin
        logic [7:0] v;
        logic o;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 p0_out", p0_out, 8'hFF);
        check("R1 p0_oe", p0_oe, 8'h00);
        check("R1 p1_out", p1_out, 8'hFF);
        check("R1 p1_oe", p1_oe, 8'h00);
        check("R1 rd_oe", {7'd0, rd_oe}, 8'h00);
        rst_n = 1; cs_n = 0;
        p0_in = 8'hA5; p1_in = 8'hC9;
        repeat (3) @(negedge clk);

        // R2 R4 R5 R8 table walk
        for (int i = 0; i < NROWS; i++) begin
            bus_write(TABLE[i][21:19], TABLE[i][18:11]);
            bus_read(TABLE[i][10:8], v, o);
            check($sformatf("R2/R4/R5/R8 row %0d", i), v, TABLE[i][7:0]);
            check($sformatf("R9 rd_oe row %0d", i), {7'd0, o}, 8'h01);
        end
        // R3 pin drive follows registers
        check("R3 p0_oe", p0_oe, 8'hFF);
        check("R3 p0_out", p0_out, 8'hAB);
        check("R3 p1_oe", p1_oe, 8'h00);
        check("R3 p1_out", p1_out, 8'h34);

        // R8 memory-space read leaves bus undriven
        bus_read(3'b011, v, o);
        check("R8 rd_oe", {7'd0, o}, 8'h00);

        // R6 two-flop synchroniser latency on port 1 (all inputs)
        @(negedge clk); sel = 3'b110; oe_n = 0; p1_in = 8'h5A;
        @(negedge clk); check("R6 after one edge", rd_data, 8'hC9);
        @(negedge clk); check("R6 after two edges", rd_data, 8'h5A);
        oe_n = 1;

        // R9 held write strobe commits only on rise
        @(negedge clk); sel = 3'b111; wr_data = 8'hFF; we_n = 0;
        repeat (3) @(negedge clk);
        check("R9 held low", p1_oe, 8'h00);
        we_n = 1;
        @(negedge clk);
        check("R9 after rise", p1_oe, 8'hFF);

        // R7 deselected: write blocked, read blocked, drive kept
        cs_n = 1;
        bus_write(3'b110, 8'h00);
        check("R7 latch kept", p1_out, 8'h34);
        check("R7 dir kept", p1_oe, 8'hFF);
        bus_read(3'b110, v, o);
        check("R7 rd_oe", {7'd0, o}, 8'h00);
        check("R7 rd_data", v, 8'h00);
        cs_n = 0;
        bus_read(3'b110, v, o);
        check("R7 reselect readback", v, 8'h34);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule